// File: doc/BRIEF.md
# Prioritised Interrupt Controller with Edge and Level Capture

This block gathers up to 32 interrupt lines into two requests for a processor. One is a normal request and one is a fast request. Each line has a configuration word that holds a priority, a sense mode and a steering bit, and the steering bit picks which of the two requests the line feeds. A latch records each line. In edge mode a rising edge sets it. In level mode a high input sets it. Software can also set a latch through a register.

For each request, an arbiter compares all pending lines that are unmasked and steered to that request. When the request's acknowledge window is open and a line is pending, the winner's number is stored as the vector code and the request is raised. The code then stays fixed until software writes the control register. That write drops the request and opens the window again. Reading a vector code also consumes the winner if that line is in edge mode.

Register access uses a word-only request channel with valid/ready and a read-response channel with valid/ready. Offsets are byte addresses of 32-bit words. A write is complete once accepted and returns no response. A read is accepted only when the response slot is empty or is being drained in the same cycle. Its data stays on the response channel until the consumer takes it.

Top module: `irq_hub`

## Requirements
- R1: After reset the mask register (offset 0x04) reads all ones. The latch register (0x00) and every line configuration word read 0, and irq_req and fiq_req are low.
- R2: An edge-mode line (configuration bit 1 = 0) sets its latch at the clock edge where its input is high after being low at the previous edge. The latch stays set after the input falls.
- R3: A level-mode line (configuration bit 1 = 1) has its latch set at every edge where its input is high. The latch clears at the first edge where the input is sampled low after being high.
- R4: A write to the latch register (0x00) ANDs the latches with the written data. A level-mode line whose input is high keeps its latch set.
- R5: The configuration word of line n sits at offset 0x1C + 4·n. Bits [6:2] hold the priority, bit 1 holds the sense mode and bit 0 holds the steering bit (1 = fast request). It reads back with all other bits 0.
- R6: A line is pending for a request when it is latched, unmasked (mask bit 0) and steered to that request. The lowest priority value wins, and a tie goes to the higher line number. If the request's window is open and any line is pending, the request rises one edge later with the winner stored as its code. The code does not change while the request stays high.
- R7: Writing the control register (0x18) with bit 0 set drops irq_req and reopens its window at that edge. Bit 1 does the same for fiq_req. The control register reads 0.
- R8: Reading 0x10 (normal) or 0x14 (fast) returns the stored code, zero-extended. If that line is in edge mode, the read clears its latch, and a level-mode latch is left unchanged. Writes to these offsets are ignored.
- R9: A write to the software-set register (0x9C) acts only on the lowest-numbered set bit, and it acts as an input assertion on that line. A level-mode line always latches. An edge-mode line latches only if its input was low at the previous edge. The register reads 0.
- R10: The mask register is read/write. A masked line never raises a request, and clearing its mask bit while the window is open raises the request one edge later.
- R11: Reads of undefined offsets return 0, and writes to them change nothing.
- R12: req_ready equals !rsp_valid || rsp_ready. An accepted read gives rsp_valid one edge later. While rsp_ready is low, rsp_valid and rsp_rdata hold. Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | NLINES | Interrupt inputs, sampled every edge |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the word |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_ready | input | 1 | Read data consumer ready |
| rsp_rdata | output | 32 | Read data |
| irq_req | output | 1 | Normal interrupt request |
| fiq_req | output | 1 | Fast interrupt request |

## Verification
An input level is sampled at an edge and lands in the latch at that same edge. The request rises on the following edge, so the bench checks twice: once after the first edge, expecting the request still low, and once after the second, expecting it high. Register writes, including control drops and mask changes, take effect at their accept edge. Read data is checked just after the edge that follows acceptance. A read returns the latch value as it stood before any clear made in the same cycle, so after a level input falls the bench lets one edge pass before reading. Every comparison is sampled on the falling clock edge, and random priority sets are checked against an arbitration function in the bench.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int ADDR_W = 8;
  localparam int PRIO_W = 5;

  localparam logic [ADDR_W-1:0] OFS_LATCH   = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_MASK    = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_VEC_IRQ = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_VEC_FIQ = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_CTRL    = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_CFG0    = 8'h1C;

  // bit order matters: priority [6:2], sense bit 1, steering bit 0
  typedef struct packed {
    logic [PRIO_W-1:0] prio;
    logic              level;
    logic              steer;
  } line_cfg_t;

  localparam int CFG_W = $bits(line_cfg_t);
endpackage

// File: rtl/irq_hub_capture.sv
module irq_hub_capture #(
  parameter int NLINES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] pins,
  input  logic [NLINES-1:0] level,
  input  logic [NLINES-1:0] keep,
  input  logic [NLINES-1:0] vec_clr,
  input  logic [NLINES-1:0] sw_one,
  output logic [NLINES-1:0] latch,
  output logic [NLINES-1:0] pins_q
);
  for (genvar n = 0; n < NLINES; n++) begin : g_line
    logic rise_set, lvl_set, fall_clr, sw_ok, hold, nxt;

    assign rise_set = pins[n] & ~pins_q[n] & ~level[n];
    assign lvl_set  = pins[n] & level[n];
    assign fall_clr = level[n] & pins_q[n] & ~pins[n];
    assign sw_ok    = sw_one[n] & (level[n] | ~pins_q[n]);
    // a level line whose input is high resists software clearing
    assign hold     = keep[n] | (level[n] & pins_q[n]);
    assign nxt      = (latch[n] & hold & ~vec_clr[n] & ~fall_clr)
                    | rise_set | lvl_set | sw_ok;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        latch[n]  <= 1'b0;
        pins_q[n] <= 1'b0;
      end else begin
        latch[n]  <= nxt;
        pins_q[n] <= pins[n];
      end
    end
  end
endmodule

// File: rtl/irq_hub_arbiter.sv
module irq_hub_arbiter #(
  parameter int NLINES = 32,
  parameter int PRIO_W = 5,
  localparam int IDX_W = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic [NLINES-1:0]        pend,
  input  logic [NLINES*PRIO_W-1:0] prio_flat,
  output logic                     any,
  output logic [IDX_W-1:0]         winner
);
  always_comb begin
    logic [PRIO_W-1:0] best;
    best   = '1;
    winner = '0;
    // ascending scan with <= lets the higher line win ties
    for (int i = 0; i < NLINES; i++) begin
      if (pend[i] && (prio_flat[i*PRIO_W +: PRIO_W] <= best)) begin
        best   = prio_flat[i*PRIO_W +: PRIO_W];
        winner = IDX_W'(i);
      end
    end
    any = |pend;
  end
endmodule

// File: rtl/irq_hub_grant.sv
module irq_hub_grant #(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             renew,
  input  logic             any,
  input  logic [IDX_W-1:0] winner,
  output logic             req_o,
  output logic [IDX_W-1:0] code_o
);
  logic open_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b1;
      req_o  <= 1'b0;
      code_o <= '0;
    end else if (renew) begin
      open_q <= 1'b1;
      req_o  <= 1'b0;
    end else if (open_q && any) begin
      open_q <= 1'b0;
      req_o  <= 1'b1;
      code_o <= winner;
    end
  end
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int NLINES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] irq_lines,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  output logic              irq_req,
  output logic              fiq_req
);
  localparam int IDX_W = (NLINES > 1) ? $clog2(NLINES) : 1;
  localparam logic [ADDR_W-1:0] OFS_SWSET = ADDR_W'(int'(OFS_CFG0) + 4 * NLINES);

  logic acc, wr_acc, rd_acc;
  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign wr_acc    = acc && req_write;
  assign rd_acc    = acc && !req_write;

  logic [NLINES-1:0] mask_q, latch_q, pins_q, level_v, steer_v;
  logic [NLINES-1:0] cfg_hit, keep, vec_clr, sw_bits, sw_one;
  logic [NLINES-1:0] code_hit [2];
  logic [NLINES*PRIO_W-1:0] prio_flat;
  line_cfg_t cfg_q [NLINES];
  logic [1:0] pend_any, grant_req;
  logic [IDX_W-1:0] grant_code [2];
  logic [IDX_W-1:0] win [2];

  // per-line configuration words
  for (genvar n = 0; n < NLINES; n++) begin : g_cfg
    assign cfg_hit[n] = (req_addr == ADDR_W'(int'(OFS_CFG0) + 4 * n));
    assign level_v[n] = cfg_q[n].level;
    assign steer_v[n] = cfg_q[n].steer;
    assign prio_flat[n*PRIO_W +: PRIO_W] = cfg_q[n].prio;
    assign code_hit[0][n] = (grant_code[0] == IDX_W'(n));
    assign code_hit[1][n] = (grant_code[1] == IDX_W'(n));

    always_ff @(posedge clk) begin
      if (!rst_n) cfg_q[n] <= '0;
      else if (wr_acc && cfg_hit[n]) cfg_q[n] <= line_cfg_t'(req_wdata[CFG_W-1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mask_q <= '1;
    else if (wr_acc && req_addr == OFS_MASK) mask_q <= req_wdata[NLINES-1:0];
  end

  // software set: isolate the lowest set bit
  assign sw_bits = req_wdata[NLINES-1:0];
  assign sw_one  = (wr_acc && req_addr == OFS_SWSET) ? (sw_bits & (~sw_bits + 1'b1)) : '0;
  assign keep    = (wr_acc && req_addr == OFS_LATCH) ? req_wdata[NLINES-1:0] : '1;

  always_comb begin
    vec_clr = '0;
    if (rd_acc && req_addr == OFS_VEC_IRQ) vec_clr = code_hit[0] & ~level_v;
    if (rd_acc && req_addr == OFS_VEC_FIQ) vec_clr = code_hit[1] & ~level_v;
  end

  irq_hub_capture #(.NLINES(NLINES)) u_capture (
    .clk    (clk),
    .rst_n  (rst_n),
    .pins   (irq_lines),
    .level  (level_v),
    .keep   (keep),
    .vec_clr(vec_clr),
    .sw_one (sw_one),
    .latch  (latch_q),
    .pins_q (pins_q)
  );

  // one arbiter and one grant stage per request output
  for (genvar g = 0; g < 2; g++) begin : g_out
    logic [NLINES-1:0] pend;
    assign pend = latch_q & ~mask_q & ((g == 1) ? steer_v : ~steer_v);

    irq_hub_arbiter #(.NLINES(NLINES), .PRIO_W(PRIO_W)) u_arb (
      .pend     (pend),
      .prio_flat(prio_flat),
      .any      (pend_any[g]),
      .winner   (win[g])
    );

    irq_hub_grant #(.IDX_W(IDX_W)) u_grant (
      .clk   (clk),
      .rst_n (rst_n),
      .renew (wr_acc && req_addr == OFS_CTRL && req_wdata[g]),
      .any   (pend_any[g]),
      .winner(win[g]),
      .req_o (grant_req[g]),
      .code_o(grant_code[g])
    );
  end

  assign irq_req = grant_req[0];
  assign fiq_req = grant_req[1];

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (req_addr == OFS_LATCH)   rd_mux = 32'(latch_q);
    if (req_addr == OFS_MASK)    rd_mux = 32'(mask_q);
    if (req_addr == OFS_VEC_IRQ) rd_mux = 32'(grant_code[0]);
    if (req_addr == OFS_VEC_FIQ) rd_mux = 32'(grant_code[1]);
    for (int n = 0; n < NLINES; n++)
      if (cfg_hit[n]) rd_mux = 32'(cfg_q[n]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (rd_acc) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_hub_checker.sv
module irq_hub_checker #(
  parameter int NLINES = 32,
  parameter int IDX_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [7:0]        req_addr,
  input logic [1:0]        ctl_bits,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [31:0]       rsp_rdata,
  input logic              irq_req,
  input logic              fiq_req,
  input logic [NLINES-1:0] latch,
  input logic [NLINES-1:0] pins_q,
  input logic [NLINES-1:0] level,
  input logic [1:0]        pend_any,
  input logic [IDX_W-1:0]  code_irq
);
  logic ctl_wr;
  assign ctl_wr = req_valid && req_ready && req_write && (req_addr == 8'h18);

  assert_irq_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_bits[0]) |=> !irq_req);

  assert_fiq_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_bits[1]) |=> !fiq_req);

  assert_rise_needs_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> $past(pend_any[0]));

  assert_code_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && $past(irq_req)) |-> $stable(code_irq));

  assert_level_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pins_q & level & ~latch) == '0);

  assert_rsp_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
endmodule

bind irq_hub irq_hub_checker #(.NLINES(NLINES), .IDX_W(IDX_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_write(req_write),
  .req_addr (req_addr),
  .ctl_bits (req_wdata[1:0]),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .rsp_rdata(rsp_rdata),
  .irq_req  (irq_req),
  .fiq_req  (fiq_req),
  .latch    (latch_q),
  .pins_q   (pins_q),
  .level    (level_v),
  .pend_any (pend_any),
  .code_irq (grant_code[0])
);

// File: tb/irq_hub_bench.sv
module irq_hub_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] irq_lines = '0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [7:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, irq_req, fiq_req;
  logic [31:0] rsp_rdata;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_hub #(.NLINES(N)) u_irq_hub (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .irq_req(irq_req), .fiq_req(fiq_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata;
  endtask

  function automatic logic [7:0] cfg_ofs(input int n);
    return 8'(8'h1C + 4 * n);
  endfunction

  // expected winner: lowest priority value, ties to the higher line
  function automatic int exp_winner(input logic [N-1:0] p, input logic [4:0] pr [N]);
    int w = 0;
    int best = 99;
    for (int i = 0; i < N; i++)
      if (p[i] && pr[i] <= best) begin best = pr[i]; w = i; end
    return w;
  endfunction

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [4:0] pr [N];
    void'($urandom(32'd20240611));
    tick(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h04, d); chk("R1 mask", d, 32'hFFFF_FFFF);
    rd(8'h00, d); chk("R1 latch", d, 0);
    rd(cfg_ofs(5), d); chk("R1 cfg", d, 0);
    chk("R1 irq_req", 32'(irq_req), 0);
    chk("R1 fiq_req", 32'(fiq_req), 0);

    // R2 edge capture, R6 timing, R8 clear on read
    wr(cfg_ofs(3), 32'h0);
    wr(8'h04, ~(32'h1 << 3));
    irq_lines[3] = 1'b1;
    tick(1); chk("R6 not yet", 32'(irq_req), 0);
    tick(1); chk("R6 raised", 32'(irq_req), 1);
    rd(8'h10, d); chk("R8 irq code", d, 3);
    rd(8'h00, d); chk("R8 edge cleared", d, 0);
    irq_lines[3] = 1'b0;
    wr(8'h18, 32'h1); chk("R7 irq drop", 32'(irq_req), 0);
    rd(8'h18, d); chk("R7 ctrl reads 0", d, 0);

    // R2 latch kept after input falls
    wr(cfg_ofs(4), 32'h0);
    irq_lines[4] = 1'b1; tick(1); irq_lines[4] = 1'b0; tick(2);
    rd(8'h00, d); chk("R2 edge kept", d, 32'h10);
    wr(8'h00, 32'h0);
    rd(8'h00, d); chk("R4 write clears edge", d, 0);

    // R3 / R4 / R8 level line
    wr(cfg_ofs(5), 32'h2);
    irq_lines[5] = 1'b1; tick(2);
    rd(8'h00, d); chk("R3 level set", d, 32'h20);
    wr(8'h00, 32'h0);
    rd(8'h00, d); chk("R4 level protected", d, 32'h20);
    wr(8'h04, ~(32'h1 << 5));
    chk("R10 unmask raises", 32'(irq_req), 0);
    tick(1); chk("R10 unmask raises", 32'(irq_req), 1);
    rd(8'h10, d); chk("R8 level code", d, 5);
    rd(8'h00, d); chk("R8 level not cleared", d, 32'h20);
    irq_lines[5] = 1'b0; tick(1);
    rd(8'h00, d); chk("R3 level falls", d, 0);
    wr(8'h18, 32'h1);
    wr(8'h04, 32'hFFFF_FFFF);

    // R9 software set, fast request steering
    wr(cfg_ofs(7), 32'h1);
    wr(8'h04, ~(32'h1 << 7));
    wr(8'h9C, (32'h1 << 7) | (32'h1 << 20));
    tick(1);
    chk("R6 fiq raised", 32'(fiq_req), 1);
    chk("R6 irq stays low", 32'(irq_req), 0);
    rd(8'h14, d); chk("R8 fiq code", d, 7);
    rd(8'h00, d); chk("R9 lowest only", d, 0);
    wr(8'h18, 32'h2); chk("R7 fiq drop", 32'(fiq_req), 0);
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h9C, (32'h1 << 12) | (32'h1 << 9));
    rd(8'h00, d); chk("R9 lowest set bit", d, 32'h1 << 9);
    rd(8'h9C, d); chk("R9 reads 0", d, 0);
    tick(2); chk("R10 masked no req", 32'(irq_req), 0);
    wr(8'h00, 32'h0);

    // R8 write ignored, R11 undefined offsets
    wr(8'h10, 32'hFF);
    rd(8'h10, d); chk("R8 write ignored", d, 5);
    rd(8'h08, d); chk("R11 undefined read", d, 0);
    wr(8'h0C, 32'h0);
    rd(8'h04, d); chk("R11 undefined write", d, 32'hFFFF_FFFF);

    // R5 config layout
    wr(cfg_ofs(10), 32'hFFFF_FFFF);
    rd(cfg_ofs(10), d); chk("R5 cfg bits", d, 32'h7F);
    wr(cfg_ofs(10), 32'h0);

    // R12 response back-pressure
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_addr = 8'h04;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    chk("R12 rsp valid", 32'(rsp_valid), 1);
    tick(1);
    chk("R12 rsp held", 32'(rsp_valid), 1);
    chk("R12 ready low", 32'(req_ready), 0);
    chk("R12 data held", rsp_rdata, 32'hFFFF_FFFF);
    rsp_ready = 1'b1;
    tick(1); chk("R12 rsp drained", 32'(rsp_valid), 0);

    // R6 random priority sets against the bench arbitration function
    for (int it = 0; it < 30; it++) begin
      logic [N-1:0] r;
      for (int n = 0; n < N; n++) begin
        pr[n] = 5'($urandom % 4);
        wr(cfg_ofs(n), {25'b0, pr[n], 2'b00});
      end
      wr(8'h04, 32'h0);
      wr(8'h00, 32'h0);
      wr(8'h18, 32'h3);
      r = (it % 7 == 0) ? '0 : N'($urandom);
      irq_lines = r;
      tick(2);
      chk("R6 random req", 32'(irq_req), 32'(r != 0));
      rd(8'h00, d); chk("R2 random latch", d, 32'(r));
      if (r != 0) begin
        rd(8'h10, d); chk("R6 random winner", d, 32'(exp_winner(r, pr)));
      end
      irq_lines = '0;
      tick(1);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule